// File: doc/BRIEF.md
# Stall Event Performance Monitor

This block sits beside a processor core and measures how much time the core loses to stalls. It keeps a free-running cycle counter and two event counters. A one-bit mode input picks what the event counters watch. In buffer-full mode they watch the stall that arises when no data-cache request buffer is free. In dependency/writeback mode they watch pipeline data-dependency stalls and data-cache writebacks.

The pairing is built so that software can derive statistics from a snapshot of the three values. Event counter 0 counts the duration of a stall, one per stalled cycle. In buffer-full mode event counter 1 counts separate stall episodes. Event counter 0 divided by the cycle counter gives the stall fraction. Event counter 0 divided by event counter 1 gives the average episode length. A common enable starts and stops all three counters together, and a common synchronous clear zeroes them together, so the ratios always come from one consistent window. Every counter wraps silently to zero and sets its own sticky overflow flag when it does.

Top module: `stall_perf_monitor`

## Requirements
- R1: After reset, or on the clock edge that follows a cycle with `clear_i` high, all three counters and all three overflow flags read zero. Clear takes priority over `enable_i`.
- R2: While `enable_i` is high and `clear_i` is low, `cycle_count_o` increases by exactly one on each clock edge.
- R3: With `mode_i` = 0 (buffer-full), `evt0_count_o` increases by one on each enabled cycle in which `buf_full_stall_i` is high.
- R4: With `mode_i` = 0, `evt1_count_o` increases by one on each enabled cycle in which `buf_full_stall_i` is high and was low in the previous cycle. A stall held for many cycles counts once. Two stalls separated by one low cycle count twice. The previous-cycle history follows the level in both modes and while disabled.
- R5: If `buf_full_stall_i` is high in the clear cycle and in the first cycle after it, that first cycle counts as a new occurrence, because the clear empties the edge history.
- R6: With `mode_i` = 1 (dependency/writeback), `evt0_count_o` increases by one on each enabled cycle in which `dep_stall_i` is high.
- R7: With `mode_i` = 1, `evt1_count_o` increases by one on each enabled cycle in which `wb_strobe_i` is high. Each such cycle is one writeback.
- R8: While `enable_i` is low and `clear_i` is low, none of the three counters changes, whatever the event inputs do.
- R9: A counter at its all-ones value that is stepped again reads zero and sets its overflow flag. The flag then stays set until a clear.
- R10: Changing `mode_i` does not alter any counter value. The new event pairing applies from the first edge at which the new mode is sampled.
- R11: Event inputs that belong to the unselected mode have no effect on either event counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global count enable |
| clear_i | input | 1 | Synchronous clear of counters, flags and edge history |
| mode_i | input | 1 | 0 = buffer-full mode, 1 = dependency/writeback mode |
| buf_full_stall_i | input | 1 | Level: core stalled because no request buffer is free |
| dep_stall_i | input | 1 | Level: core stalled on a data dependency |
| wb_strobe_i | input | 1 | One per cycle: the data cache issued a writeback |
| cycle_count_o | output | CNT_W | Cycle counter value |
| evt0_count_o | output | CNT_W | Event counter 0 (stall duration) |
| evt1_count_o | output | CNT_W | Event counter 1 (occurrences or writebacks) |
| cycle_ovf_o | output | 1 | Sticky wrap flag of the cycle counter |
| evt0_ovf_o | output | 1 | Sticky wrap flag of event counter 0 |
| evt1_ovf_o | output | 1 | Sticky wrap flag of event counter 1 |

## Verification
The bench builds the monitor with `CNT_W` = 8 in place of the default 32. This makes the wrap boundary reachable within a few hundred cycles. A held buffer-full stall then drives the cycle counter and event counter 0 through zero together, while event counter 1 stays at one. That run shows the sticky flags setting on the wrap edge, staying set afterwards, and falling only on a clear. The narrow width does not change any rise-detect or mode-pairing path, so the same sequences also cover the R4, R5 and R10 edge cases.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef enum logic {
    SPM_MODE_BUFFULL = 1'b0,
    SPM_MODE_DEPWB   = 1'b1
  } spm_mode_e;

  localparam int unsigned SPM_NUM_CTRS = 3;
  localparam int unsigned SPM_IDX_CYC  = 0;
  localparam int unsigned SPM_IDX_EV0  = 1;
  localparam int unsigned SPM_IDX_EV1  = 2;

  // Duration source: one per cycle of the selected stall level.
  function automatic logic spm_duration_src(spm_mode_e mode,
                                            logic bufful,
                                            logic dep);
    return (mode == SPM_MODE_DEPWB) ? dep : bufful;
  endfunction

  // Occurrence source: buffer-full rising edge, or a writeback strobe.
  function automatic logic spm_occurrence_src(spm_mode_e mode,
                                              logic bufful_rise,
                                              logic wb);
    return (mode == SPM_MODE_DEPWB) ? wb : bufful_rise;
  endfunction

endpackage

// File: rtl/spm_rise_detect.sv
module spm_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic level,
  output logic rise
);

  logic level_prev_q;

  // History follows the level every cycle; a clear empties it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_prev_q <= 1'b0;
    end else if (clear) begin
      level_prev_q <= 1'b0;
    end else begin
      level_prev_q <= level;
    end
  end

  assign rise = level & ~level_prev_q;

  // A rise with no clear cannot repeat on the next cycle.
  assert_single_rise_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
      (rise && !clear) |=> !rise
  );

endmodule

// File: rtl/spm_event_select.sv
module spm_event_select
  import spm_pkg::*;
(
  input  spm_mode_e mode,
  input  logic      bufful_level,
  input  logic      bufful_rise,
  input  logic      dep_level,
  input  logic      wb_strobe,
  output logic      ev0_hit,
  output logic      ev1_hit
);

  always_comb begin
    ev0_hit = spm_duration_src(mode, bufful_level, dep_level);
    ev1_hit = spm_occurrence_src(mode, bufful_rise, wb_strobe);
  end

endmodule

// File: rtl/spm_counter.sv
module spm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Increment with carry out, kept as a function for reuse.
  function automatic logic [CNT_W:0] bump(logic [CNT_W-1:0] v);
    return {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  logic [CNT_W:0] bumped;
  logic           wrap_now;

  assign bumped   = bump(count);
  assign wrap_now = step & bumped[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clear) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (step)     count <= bumped[CNT_W-1:0];
      if (wrap_now) ovf   <= 1'b1;
    end
  end

  assert_wrap_sets_flag_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
      (step && !clear && count == CNT_MAX) |=> (count == '0 && ovf)
  );

  assert_flag_sticky_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
      (ovf && !clear) |=> ovf
  );

  assert_hold_without_step_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> $stable(count)
  );

endmodule

// File: rtl/stall_perf_monitor.sv
module stall_perf_monitor
  import spm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             clear_i,
  input  logic             mode_i,
  input  logic             buf_full_stall_i,
  input  logic             dep_stall_i,
  input  logic             wb_strobe_i,
  output logic [CNT_W-1:0] cycle_count_o,
  output logic [CNT_W-1:0] evt0_count_o,
  output logic [CNT_W-1:0] evt1_count_o,
  output logic             cycle_ovf_o,
  output logic             evt0_ovf_o,
  output logic             evt1_ovf_o
);

  localparam int unsigned NC = SPM_NUM_CTRS;

  spm_mode_e        mode_sel;
  logic             bufful_rise;
  logic             ev0_hit;
  logic             ev1_hit;
  logic [NC-1:0]    ctr_step;
  logic [NC-1:0]    ctr_ovf;
  logic [CNT_W-1:0] ctr_val [NC];

  assign mode_sel = spm_mode_e'(mode_i);

  spm_rise_detect u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear_i),
    .level (buf_full_stall_i),
    .rise  (bufful_rise)
  );

  spm_event_select u_sel (
    .mode         (mode_sel),
    .bufful_level (buf_full_stall_i),
    .bufful_rise  (bufful_rise),
    .dep_level    (dep_stall_i),
    .wb_strobe    (wb_strobe_i),
    .ev0_hit      (ev0_hit),
    .ev1_hit      (ev1_hit)
  );

  assign ctr_step[SPM_IDX_CYC] = enable_i;
  assign ctr_step[SPM_IDX_EV0] = enable_i & ev0_hit;
  assign ctr_step[SPM_IDX_EV1] = enable_i & ev1_hit;

  for (genvar gi = 0; gi < NC; gi++) begin : g_ctr
    spm_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear_i),
      .step  (ctr_step[gi]),
      .count (ctr_val[gi]),
      .ovf   (ctr_ovf[gi])
    );
  end

  assign cycle_count_o = ctr_val[SPM_IDX_CYC];
  assign evt0_count_o  = ctr_val[SPM_IDX_EV0];
  assign evt1_count_o  = ctr_val[SPM_IDX_EV1];
  assign cycle_ovf_o   = ctr_ovf[SPM_IDX_CYC];
  assign evt0_ovf_o    = ctr_ovf[SPM_IDX_EV0];
  assign evt1_ovf_o    = ctr_ovf[SPM_IDX_EV1];

  assert_clear_zeroes_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
      clear_i |=> (cycle_count_o == '0 && evt0_count_o == '0 &&
                   evt1_count_o == '0 && !cycle_ovf_o &&
                   !evt0_ovf_o && !evt1_ovf_o)
  );

  assert_cycle_step_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
      (enable_i && !clear_i) |=>
        ((cycle_count_o - $past(cycle_count_o)) == {{(CNT_W-1){1'b0}}, 1'b1})
  );

  assert_freeze_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      (!enable_i && !clear_i) |=>
        ($stable(cycle_count_o) && $stable(evt0_count_o) && $stable(evt1_count_o))
  );

  assert_event_at_most_one_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
      (!clear_i) |=>
        ((evt0_count_o - $past(evt0_count_o)) <= {{(CNT_W-1){1'b0}}, 1'b1})
  );

endmodule

// File: tb/stall_perf_monitor_tb.sv
`timescale 1ns/1ps
module stall_perf_monitor_tb;

  localparam int unsigned BW = 8;

  typedef struct {
    logic [BW-1:0] cyc;
    logic [BW-1:0] e0;
    logic [BW-1:0] e1;
    logic [2:0]    fl;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, clr = 1'b0, md = 1'b0, bf = 1'b0, dp = 1'b0, wb = 1'b0;
  logic [BW-1:0] cyc_o, e0_o, e1_o;
  logic cyc_f, e0_f, e1_f;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  exp_t q[$];

  // Independent reference state
  logic [BW-1:0] r_cyc = '0, r_e0 = '0, r_e1 = '0;
  logic [2:0]    r_fl = '0;
  logic          r_last_bf = 1'b0;

  always #2 clk = ~clk;

  stall_perf_monitor #(.CNT_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .clear_i(clr), .mode_i(md),
    .buf_full_stall_i(bf), .dep_stall_i(dp), .wb_strobe_i(wb),
    .cycle_count_o(cyc_o), .evt0_count_o(e0_o), .evt1_count_o(e1_o),
    .cycle_ovf_o(cyc_f), .evt0_ovf_o(e0_f), .evt1_ovf_o(e1_f)
  );

  function automatic logic [BW:0] add1(logic [BW-1:0] v, logic s);
    return {1'b0, v} + {{BW{1'b0}}, s};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic i_en, logic i_cl, logic i_md, logic i_bf,
                       logic i_dp, logic i_wb, string tag);
    logic [BW:0] s;
    logic occ;
    exp_t it;
    @(negedge clk);
    en = i_en; clr = i_cl; md = i_md; bf = i_bf; dp = i_dp; wb = i_wb;
    if (i_cl) begin
      r_cyc = '0; r_e0 = '0; r_e1 = '0; r_fl = '0; r_last_bf = 1'b0;
    end else begin
      occ = i_md ? i_wb : (i_bf && !r_last_bf);
      if (i_en) begin
        s = add1(r_cyc, 1'b1);            r_cyc = s[BW-1:0]; r_fl[0] |= s[BW];
        s = add1(r_e0, i_md ? i_dp : i_bf); r_e0 = s[BW-1:0]; r_fl[1] |= s[BW];
        s = add1(r_e1, occ);              r_e1 = s[BW-1:0]; r_fl[2] |= s[BW];
      end
      r_last_bf = i_bf;
    end
    it.cyc = r_cyc; it.e0 = r_e0; it.e1 = r_e1; it.fl = r_fl; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares one expected item after each driven edge
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(cyc_o == it.cyc, it.tag, "cycle_count", cyc_o, it.cyc);
        check(e0_o == it.e0, it.tag, "evt0_count", e0_o, it.e0);
        check(e1_o == it.e1, it.tag, "evt1_count", e1_o, it.e1);
        check({e1_f, e0_f, cyc_f} == it.fl, it.tag, "ovf_flags",
              {e1_f, e0_f, cyc_f}, it.fl);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(cyc_o == 0 && e0_o == 0 && e1_o == 0, "R1", "reset counts",
          cyc_o + e0_o + e1_o, 0);
    check({cyc_f, e0_f, e1_f} == 3'b000, "R1", "reset flags",
          {cyc_f, e0_f, e1_f}, 0);

    drive(1, 1, 0, 0, 0, 0, "R1");
    // R2/R3/R4: held stall counts once, one-cycle gap counts twice
    drive(1, 0, 0, 1, 0, 0, "R4");
    drive(1, 0, 0, 1, 0, 0, "R3");
    drive(1, 0, 0, 1, 0, 0, "R4");
    drive(1, 0, 0, 0, 0, 0, "R2");
    drive(1, 0, 0, 1, 0, 0, "R4");
    drive(1, 0, 0, 0, 0, 0, "R3");
    // R11: other-mode inputs ignored in buffer-full mode
    drive(1, 0, 0, 0, 1, 1, "R11");
    drive(1, 0, 0, 0, 1, 1, "R11");
    // R5: stall high through the clear and just after it
    drive(1, 1, 0, 1, 0, 0, "R5");
    drive(1, 0, 0, 1, 0, 0, "R5");
    drive(1, 0, 0, 1, 0, 0, "R5");
    // R6/R7: dependency/writeback mode
    drive(1, 0, 1, 0, 1, 0, "R6");
    drive(1, 0, 1, 0, 1, 0, "R6");
    drive(1, 0, 1, 0, 0, 1, "R7");
    drive(1, 0, 1, 1, 0, 1, "R7");
    drive(1, 0, 1, 0, 0, 0, "R11");
    drive(1, 0, 1, 1, 0, 0, "R11");
    drive(1, 0, 1, 0, 0, 0, "R11");
    // R10: mode switches keep values, new pairing immediately
    drive(1, 0, 0, 0, 1, 1, "R10");
    drive(1, 0, 0, 1, 1, 0, "R10");
    drive(1, 0, 1, 1, 1, 0, "R10");
    drive(1, 0, 0, 1, 0, 1, "R10");
    // R8: disabled, events present
    drive(0, 0, 0, 0, 0, 0, "R8");
    drive(0, 0, 0, 1, 0, 0, "R8");
    drive(0, 0, 0, 1, 0, 0, "R8");
    drive(0, 0, 1, 0, 1, 1, "R8");
    drive(1, 0, 0, 1, 0, 0, "R4");
    // R9: wrap and sticky flags
    drive(1, 1, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 300; i++) drive(1, 0, 0, 1, 0, 0, "R9");
    drive(1, 0, 0, 0, 0, 0, "R9");
    drive(0, 0, 0, 0, 0, 0, "R9");
    drive(1, 0, 1, 0, 0, 0, "R9");
    drive(1, 1, 0, 1, 1, 1, "R1");
    drive(1, 0, 0, 0, 0, 0, "R2");
    repeat (3) @(posedge clk);
    #1;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule